// File: doc/BRIEF.md
# Clip Window Range Method Unit

This block decodes the two clip-window methods of a 3D drawing surface. Each method write carries a 32-bit word that packs a start coordinate and a signed extent. The unit turns that word into an inclusive window for one axis: a 16-bit minimum and an 18-bit maximum. Horizontal writes update the X pair and vertical writes update the Y pair.

A write whose start coordinate is too large is refused. It produces a one-cycle error pulse and leaves every bound register as it was. Writes may arrive on consecutive cycles and are never stalled. Testing pixels against the window is done elsewhere, and this unit only keeps the bounds.

Top module: `clipwin_unit`

## Requirements
- R1: The start coordinate is taken from data bits 15:0 and the extent from data bits 31:16.
- R2: A strobed write whose start has bit 15 set raises `rej_pulse` for exactly the one cycle after that strobe.
- R3: A refused write leaves all four bound registers unchanged.
- R4: The extent is a 16-bit two's-complement number, so negative extents are legal. The maximum bound becomes (start + sign-extended extent) modulo 2^18.
- R5: On an accepted write the minimum bound of the selected axis becomes the 16-bit start unchanged.
- R6: With `axis_sel` = 0 an accepted write loads only the X pair; with `axis_sel` = 1 it loads only the Y pair.
- R7: Bounds change on the clock edge that samples the accepted strobe, so the new values appear one cycle after the strobe. Without a strobe, nothing changes.
- R8: Synchronous reset sets both minimum bounds to 0, both maximum bounds to 0x3FFFF and `rej_pulse` to 0.
- R9: Strobes on back-to-back cycles are each handled in full, with no stall and no lost write.
- R10: An accepted write leaves `rej_pulse` low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mth_valid | input | 1 | Method write strobe |
| axis_sel | input | 1 | 0 = horizontal (X), 1 = vertical (Y) |
| mth_data | input | 32 | Packed extent (31:16) and start (15:0) |
| x_lo | output | 16 | X minimum bound |
| x_hi | output | 18 | X maximum bound |
| y_lo | output | 16 | Y minimum bound |
| y_hi | output | 18 | Y maximum bound |
| rej_pulse | output | 1 | One-cycle flag for a refused write |

## Verification
The embedded properties check on every cycle:
- that a refused write pulses the error flag and freezes all bounds;
- that an idle cycle changes nothing;
- that a horizontal write never disturbs Y, and a vertical write never disturbs X;
- that stored minimums never hold a start with bit 15 set.

The arithmetic of the maximum bound can only be shown by the bench's reference model over chosen scenarios. This includes negative extents wrapping below zero, large positive sums, alternating axes on back-to-back cycles, and a refusal followed directly by an accepted write.

// File: rtl/clipwin_pkg.sv
package clipwin_pkg;

    localparam int DATA_W  = 32;
    localparam int START_W = 16;
    localparam int EXT_W   = DATA_W - START_W;
    localparam int BOUND_W = 18;
    localparam int NUM_AXES = 2;

    localparam logic [BOUND_W-1:0] HI_RESET = {BOUND_W{1'b1}};

    typedef enum logic {
        AXIS_X = 1'b0,
        AXIS_Y = 1'b1
    } axis_e;

    typedef struct packed {
        logic [START_W-1:0] lo;
        logic [BOUND_W-1:0] hi;
    } window_t;

    // Inclusive maximum: start plus sign-extended extent, wrapped to BOUND_W bits
    function automatic logic [BOUND_W-1:0] window_max(
        input logic [START_W-1:0] start,
        input logic [EXT_W-1:0]   extent
    );
        logic [BOUND_W-1:0] s_ext;
        logic [BOUND_W-1:0] e_ext;
        s_ext = {{(BOUND_W-START_W){1'b0}}, start};
        e_ext = {{(BOUND_W-EXT_W){extent[EXT_W-1]}}, extent};
        return s_ext + e_ext;
    endfunction

endpackage

// File: rtl/clipwin_decode.sv
module clipwin_decode
    import clipwin_pkg::*;
(
    input  logic [DATA_W-1:0] word,
    output window_t           win,
    output logic              bad
);
    logic [START_W-1:0] start_f;
    logic [EXT_W-1:0]   extent_f;

    always_comb begin
        start_f  = word[START_W-1:0];
        extent_f = word[DATA_W-1:START_W];
        bad      = start_f[START_W-1];
        win.lo   = start_f;
        win.hi   = window_max(start_f, extent_f);
    end
endmodule

// File: rtl/clipwin_axis_reg.sv
module clipwin_axis_reg
    import clipwin_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  window_t win_in,
    output window_t win_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            win_q.lo <= '0;
            win_q.hi <= HI_RESET;
        end else if (load) begin
            win_q <= win_in;
        end
    end

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(win_q));

    // R5
    lo_follow_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (win_q.lo == $past(win_in.lo)));
endmodule

// File: rtl/clipwin_unit.sv
module clipwin_unit
    import clipwin_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                mth_valid,
    input  logic                axis_sel,
    input  logic [DATA_W-1:0]   mth_data,
    output logic [START_W-1:0]  x_lo,
    output logic [BOUND_W-1:0]  x_hi,
    output logic [START_W-1:0]  y_lo,
    output logic [BOUND_W-1:0]  y_hi,
    output logic                rej_pulse
);
    window_t dec_win;
    logic    dec_bad;
    window_t axis_q [NUM_AXES];
    logic    accept;

    clipwin_decode u_dec (
        .word (mth_data),
        .win  (dec_win),
        .bad  (dec_bad)
    );

    assign accept = mth_valid && !dec_bad;

    for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
        logic sel_hit;
        assign sel_hit = (axis_sel == a[0]);
        clipwin_axis_reg u_reg (
            .clk    (clk),
            .rst    (rst),
            .load   (accept && sel_hit),
            .win_in (dec_win),
            .win_q  (axis_q[a])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) rej_pulse <= 1'b0;
        else     rej_pulse <= mth_valid && dec_bad;
    end

    assign x_lo = axis_q[AXIS_X].lo;
    assign x_hi = axis_q[AXIS_X].hi;
    assign y_lo = axis_q[AXIS_Y].lo;
    assign y_hi = axis_q[AXIS_Y].hi;

    // R2
    reject_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (mth_valid && mth_data[START_W-1]) |=> rej_pulse);

    // R10
    accept_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mth_valid && !mth_data[START_W-1]) |=> !rej_pulse);

    // R3
    reject_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mth_valid && mth_data[START_W-1]) |=>
            ($stable(x_lo) && $stable(x_hi) && $stable(y_lo) && $stable(y_hi)));

    // R6
    x_only_chk: assert property (@(posedge clk) disable iff (rst)
        (mth_valid && !axis_sel) |=> ($stable(y_lo) && $stable(y_hi)));

    // R6
    y_only_chk: assert property (@(posedge clk) disable iff (rst)
        (mth_valid && axis_sel) |=> ($stable(x_lo) && $stable(x_hi)));

    // R5
    lo_range_chk: assert property (@(posedge clk) disable iff (rst)
        !x_lo[START_W-1] && !y_lo[START_W-1]);
endmodule

// File: tb/clipwin_unit_test.sv
module clipwin_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mth_valid = 1'b0;
    logic        axis_sel = 1'b0;
    logic [31:0] mth_data = '0;
    logic [15:0] x_lo, y_lo;
    logic [17:0] x_hi, y_hi;
    logic        rej_pulse;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference state (value expected after the most recent edge)
    int m_xlo, m_xhi, m_ylo, m_yhi, m_rej;

    always #5 clk = ~clk;

    clipwin_unit uut (
        .clk(clk), .rst(rst), .mth_valid(mth_valid), .axis_sel(axis_sel),
        .mth_data(mth_data), .x_lo(x_lo), .x_hi(x_hi), .y_lo(y_lo),
        .y_hi(y_hi), .rej_pulse(rej_pulse)
    );

    task automatic cmp(input string tag, input string name, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, name, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        cmp(tag, "x_lo", int'(x_lo), m_xlo);
        cmp(tag, "x_hi", int'(x_hi), m_xhi);
        cmp(tag, "y_lo", int'(y_lo), m_ylo);
        cmp(tag, "y_hi", int'(y_hi), m_yhi);
        cmp(tag, "rej_pulse", int'(rej_pulse), m_rej);
    endtask

    // Called at a falling edge: checks outputs from the last rising edge,
    // then drives a new input and advances the model over the coming edge.
    task automatic step(input string tag, input bit v, input bit vert, input logic [31:0] d);
        int s, e, h;
        compare_all(tag);
        mth_valid = v;
        axis_sel  = vert;
        mth_data  = d;
        s = int'(d[15:0]);
        e = int'(d[31:16]);
        if (e >= 32768) e = e - 65536;
        h = (s + e) & 32'h3FFFF;
        m_rej = (v && d[15]) ? 1 : 0;
        if (v && !d[15]) begin
            if (vert) begin m_ylo = s; m_yhi = h; end
            else      begin m_xlo = s; m_xhi = h; end
        end
        @(negedge clk);
    endtask

    initial begin
        m_xlo = 0; m_ylo = 0; m_xhi = 'h3FFFF; m_yhi = 'h3FFFF; m_rej = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8 reset values, with idle cycles (R7)
        step("R8", 0, 0, 32'h0);
        step("R7", 0, 1, 32'h0010_0020);
        // R1 R4 positive extent horizontal, R6 X only
        step("R1", 1, 0, 32'h0100_0040);
        step("R6", 1, 1, 32'h0020_0300);
        // R4 negative extent wrapping below zero
        step("R4", 1, 0, 32'hFFF6_0005);
        // R4 largest positive sum
        step("R4", 1, 1, 32'h7FFF_7FFF);
        // R2 R3 refused writes on both axes
        step("R2", 1, 0, 32'h0004_8000);
        step("R3", 1, 1, 32'h1234_FFFF);
        // R10 accepted directly after refusal, R9 back to back
        step("R10", 1, 0, 32'h8000_7FFF);
        step("R9", 1, 1, 32'h0000_0000);
        step("R9", 1, 0, 32'hFFFF_0000);
        step("R7", 0, 0, 32'h0001_8001);
        step("R5", 1, 1, 32'h0003_1234);
        // mixed patterns
        for (int i = 0; i < 200; i++) begin
            logic [31:0] d;
            d = 32'(i * 32'h9E37_79B9 + 32'h1357);
            step("R9", (i % 5) != 4, i[0], d);
        end
        step("R7", 0, 0, 32'h0);
        compare_all("R7");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule